// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Aligner

This block sits between the operand stage of a 32-bit core and its data memory port. For every load or store it forms the byte address from a base register plus either a zero-extended 16-bit displacement, a second register, or that register scaled by the access width. It then places the operand on the right byte lanes of the 32-bit memory word and returns load results extracted and extended to 64 bits. Byte order within the word is picked per request by an endianness input.

Accesses of 8, 16 and 32 bits take one memory beat. A 64-bit access takes two beats, at the address and at the address plus four, and holds off the next request for one cycle. Addresses that are not a multiple of the access width are flagged and produce no memory beat. Memory returns read data on `mem_rdata` during the cycle after the beat is presented, and the block samples it at the end of that cycle.

Top module: `lsu_lane_align`

## Requirements
- R1: With `req_mode` = 0 the address is `req_base` plus `req_disp` zero-extended to 32 bits (a displacement of 0x8000 adds 32768, never subtracts).
- R2: With `req_mode` = 1 or 3 the address is `req_base` + `req_index`.
- R3: With `req_mode` = 2 the address is `req_base` + `req_index` × (1 << `req_size`), with `req_size` 0/1/2/3 for 8/16/32/64 bits.
- R4: Stores place the operand's low bytes on byte lanes and raise `mem_be` for them only, other lanes of `mem_wdata` zero. Lane i is `mem_wdata[8i+7:8i]`. With address offset o (bits 1:0) and width n bytes, the first lane is o when `big_endian` = 0 and 4−n−o when `big_endian` = 1.
- R5: Loads of 8, 16 and 32 bits take the value from the same lanes as R4 and extend it to 64 bits, sign-extended when `req_sext` = 1 and zero-extended when 0.
- R6: An address that is not a multiple of the access width raises `misalign` for one cycle, in the cycle after acceptance, with `mem_valid` low then, and produces no `ld_valid`.
- R7: A 64-bit access presents two beats in consecutive cycles, at the address and at the address + 4, with all four enables; `req_ready` is low during the first beat, so the next request is taken two cycles after a 64-bit one.
- R8: For 64-bit accesses, the beat at the lower address carries bits 63:32 when `big_endian` = 1 and bits 31:0 when `big_endian` = 0, for stores and for assembled load results.
- R9: A request is accepted on a rising edge with `req_valid` and `req_ready` high; its first beat appears in the following cycle; narrow requests can be accepted every cycle; `ld_valid` pulses one cycle, two cycles after the first beat for narrow loads and three for 64-bit loads.
- R10: While `rst` is high, `mem_valid`, `misalign` and `ld_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | 0 displacement, 1/3 register pair, 2 scaled index |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| req_sext | input | 1 | Sign-extend narrow load results |
| big_endian | input | 1 | 1 = big-endian byte order for this request |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| req_disp | input | 16 | Unsigned displacement |
| req_wdata | input | 64 | Store operand, right-justified |
| mem_valid | output | 1 | Memory beat present |
| mem_write | output | 1 | Beat is a write |
| mem_addr | output | 32 | Byte address of the beat |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Read data, one cycle after the beat |
| misalign | output | 1 | Misaligned request dropped |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Extended or assembled load result |

## Verification
The bench aims at the lane arithmetic in both byte orders at every offset, where a design that mirrored the wrong way would pick the neighbouring byte or raise enables on the opposite half of the word. It drives a displacement with bit 15 set, which a sign-extending adder would turn into a lower address, and scaled indices of every width, which a wrong shift would send to the wrong word. 64-bit accesses are driven in both orders and followed at once by another request, so swapped halves, a missing +4 on the second beat, or a request taken while the second beat is still pending would each show up. Misaligned requests of each width check that no beat and no load result escape.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int DISP_W = 16;
    localparam int WORD_B = WORD_W / 8;
    localparam int OFF_W  = $clog2(WORD_B);
    localparam int DBL_W  = 2 * WORD_W;

    typedef enum logic [1:0] {
        AM_DISP     = 2'd0,
        AM_PAIR     = 2'd1,
        AM_SCALED   = 2'd2,
        AM_PAIR_ALT = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } asize_e;

    // descriptor that follows a beat through the response path
    typedef struct packed {
        asize_e           size;
        logic [OFF_W-1:0] off;
        logic             sext;
        logic             big;
        logic             dbl;
        logic             last;
    } beat_desc_t;

    // first byte lane used by a sub-word access
    function automatic logic [OFF_W-1:0] lane_base(
        input asize_e size, input logic [OFF_W-1:0] off, input logic big);
        logic [OFF_W-1:0] r;
        case (size)
            SZ_BYTE: r = big ? (OFF_W'(WORD_B - 1) - off) : off;
            SZ_HALF: r = big ? (OFF_W'(WORD_B - 2) - off) : off;
            default: r = '0;
        endcase
        return r;
    endfunction

    // enables for an access placed at lane zero
    function automatic logic [WORD_B-1:0] lane_mask(input asize_e size);
        logic [WORD_B-1:0] m;
        case (size)
            SZ_BYTE: m = WORD_B'(1);
            SZ_HALF: m = WORD_B'(3);
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lsa_agen.sv
module lsa_agen
    import lsa_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DISP_W
) (
    input  amode_e          mode,
    input  asize_e          size,
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   index,
    input  logic [DW-1:0]   disp,
    output logic [AW-1:0]   ea,
    output logic            misaligned
);
    localparam int PAD_W = AW - DW;

    logic [AW-1:0] disp_ext;
    logic [AW-1:0] index_scaled;
    logic [AW-1:0] addend;

    assign disp_ext     = {{PAD_W{1'b0}}, disp};
    assign index_scaled = index << size;

    always_comb begin
        case (mode)
            AM_DISP:   addend = disp_ext;
            AM_SCALED: addend = index_scaled;
            default:   addend = index;
        endcase
    end

    assign ea = base + addend;

    always_comb begin
        case (size)
            SZ_BYTE:  misaligned = 1'b0;
            SZ_HALF:  misaligned = ea[0];
            SZ_WORD:  misaligned = |ea[1:0];
            default:  misaligned = |ea[2:0];
        endcase
    end

endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
    import lsa_pkg::*;
(
    input  asize_e              size,
    input  logic [OFF_W-1:0]    off,
    input  logic                big,
    input  logic [DBL_W-1:0]    sdata,
    output logic [WORD_B-1:0]   be0,
    output logic [WORD_W-1:0]   wd0,
    output logic [WORD_W-1:0]   wd1
);
    logic [OFF_W-1:0]  lb;
    logic [WORD_B-1:0] mask0;
    logic [WORD_W-1:0] dmask;
    logic [WORD_W-1:0] lo_word;
    logic [WORD_W-1:0] hi_word;

    assign lb      = lane_base(size, off, big);
    assign mask0   = lane_mask(size);
    assign lo_word = sdata[WORD_W-1:0];
    assign hi_word = sdata[DBL_W-1:WORD_W];

    for (genvar i = 0; i < WORD_B; i++) begin : g_dmask
        assign dmask[8*i +: 8] = {8{mask0[i]}};
    end

    always_comb begin
        if (size == SZ_DWORD) begin
            be0 = '1;
            wd0 = big ? hi_word : lo_word;
            wd1 = big ? lo_word : hi_word;
        end else begin
            be0 = mask0 << lb;
            wd0 = (lo_word & dmask) << {lb, 3'b000};
            wd1 = '0;
        end
    end

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
(
    input  beat_desc_t          desc,
    input  logic [WORD_W-1:0]   word,
    input  logic [WORD_W-1:0]   first_word,
    output logic [DBL_W-1:0]    result
);
    localparam int HALF_W = WORD_W / 2;

    logic [OFF_W-1:0]  lb;
    logic [WORD_W-1:0] shifted;

    assign lb      = lane_base(desc.size, desc.off, desc.big);
    assign shifted = word >> {lb, 3'b000};

    always_comb begin
        case (desc.size)
            SZ_BYTE:
                result = {{(DBL_W-8){desc.sext & shifted[7]}}, shifted[7:0]};
            SZ_HALF:
                result = {{(DBL_W-HALF_W){desc.sext & shifted[HALF_W-1]}},
                          shifted[HALF_W-1:0]};
            SZ_WORD:
                result = {{(DBL_W-WORD_W){desc.sext & word[WORD_W-1]}}, word};
            default:
                result = desc.big ? {first_word, word} : {word, first_word};
        endcase
    end

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsa_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_store,
    input  logic [1:0]          req_mode,
    input  logic [1:0]          req_size,
    input  logic                req_sext,
    input  logic                big_endian,
    input  logic [ADDR_W-1:0]   req_base,
    input  logic [ADDR_W-1:0]   req_index,
    input  logic [DISP_W-1:0]   req_disp,
    input  logic [DBL_W-1:0]    req_wdata,
    output logic                mem_valid,
    output logic                mem_write,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_B-1:0]   mem_be,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                misalign,
    output logic                ld_valid,
    output logic [DBL_W-1:0]    ld_data
);
    amode_e            mode_in;
    asize_e            size_in;
    logic [ADDR_W-1:0] ea;
    logic              ea_bad;
    logic [WORD_B-1:0] st_be0;
    logic [WORD_W-1:0] st_wd0;
    logic [WORD_W-1:0] st_wd1;
    logic              accept;
    beat_desc_t        new_desc;

    // second-beat holding state
    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [WORD_W-1:0] pend_wdata_q;
    beat_desc_t        pend_desc_q;

    // response tracking
    beat_desc_t        cur_desc_q;
    beat_desc_t        rsp_desc_q;
    logic              rsp_act_q;
    logic [WORD_W-1:0] first_word_q;
    logic [DBL_W-1:0]  ext_data;

    assign mode_in   = amode_e'(req_mode);
    assign size_in   = asize_e'(req_size);
    assign req_ready = !pend_q;
    assign accept    = req_valid && req_ready;

    lsa_agen u_agen (
        .mode       (mode_in),
        .size       (size_in),
        .base       (req_base),
        .index      (req_index),
        .disp       (req_disp),
        .ea         (ea),
        .misaligned (ea_bad)
    );

    lsa_store_lane u_lane (
        .size  (size_in),
        .off   (ea[OFF_W-1:0]),
        .big   (big_endian),
        .sdata (req_wdata),
        .be0   (st_be0),
        .wd0   (st_wd0),
        .wd1   (st_wd1)
    );

    always_comb begin
        new_desc      = '0;
        new_desc.size = size_in;
        new_desc.off  = ea[OFF_W-1:0];
        new_desc.sext = req_sext;
        new_desc.big  = big_endian;
        new_desc.dbl  = (size_in == SZ_DWORD);
        new_desc.last = 1'b0;
    end

    // request side: beat issue and second-beat sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q       <= 1'b0;
            pend_addr_q  <= '0;
            pend_wdata_q <= '0;
            pend_desc_q  <= '0;
            cur_desc_q   <= '0;
            mem_valid    <= 1'b0;
            mem_write    <= 1'b0;
            mem_addr     <= '0;
            mem_be       <= '0;
            mem_wdata    <= '0;
            misalign     <= 1'b0;
        end else begin
            misalign <= 1'b0;
            if (pend_q) begin
                mem_valid       <= 1'b1;
                mem_addr        <= pend_addr_q;
                mem_be          <= '1;
                mem_wdata       <= pend_wdata_q;
                cur_desc_q      <= pend_desc_q;
                pend_q          <= 1'b0;
            end else if (accept && ea_bad) begin
                mem_valid <= 1'b0;
                misalign  <= 1'b1;
            end else if (accept) begin
                mem_valid  <= 1'b1;
                mem_write  <= req_store;
                mem_addr   <= ea;
                mem_be     <= st_be0;
                mem_wdata  <= st_wd0;
                cur_desc_q <= new_desc;
                if (new_desc.dbl) begin
                    pend_q            <= 1'b1;
                    pend_addr_q       <= ea + ADDR_W'(WORD_B);
                    pend_wdata_q      <= st_wd1;
                    pend_desc_q       <= new_desc;
                    pend_desc_q.last  <= 1'b1;
                end
            end else begin
                mem_valid <= 1'b0;
            end
        end
    end

    lsa_load_extract u_extract (
        .desc       (rsp_desc_q),
        .word       (mem_rdata),
        .first_word (first_word_q),
        .result     (ext_data)
    );

    // response side: data arrives the cycle after its beat
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_act_q    <= 1'b0;
            rsp_desc_q   <= '0;
            first_word_q <= '0;
            ld_valid     <= 1'b0;
            ld_data      <= '0;
        end else begin
            rsp_act_q  <= mem_valid && !mem_write;
            rsp_desc_q <= cur_desc_q;
            ld_valid   <= 1'b0;
            if (rsp_act_q) begin
                if (rsp_desc_q.dbl && !rsp_desc_q.last) begin
                    first_word_q <= mem_rdata;
                end else begin
                    ld_valid <= 1'b1;
                    ld_data  <= ext_data;
                end
            end
        end
    end

endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk
    import lsa_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_ready,
    input logic                mem_valid,
    input logic                mem_write,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [WORD_B-1:0]   mem_be,
    input logic [WORD_W-1:0]   mem_wdata,
    input logic                misalign,
    input logic                ld_valid
);
    logic [WORD_W-1:0] be_bits;

    always_comb begin
        for (int i = 0; i < WORD_B; i++) begin
            be_bits[8*i +: 8] = {8{mem_be[i]}};
        end
    end

    // R10: reset leaves the outputs idle
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (!mem_valid && !misalign && !ld_valid && req_ready));

    // R6: a dropped request never coincides with a beat
    a_r6_no_beat_on_misalign: assert property (@(posedge clk) disable iff (rst)
        $onehot0({misalign, mem_valid}));

    // R4: write data confined to enabled lanes
    a_r4_store_lanes: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write) |-> ((mem_wdata & ~be_bits) == '0 && mem_be != '0));

    // R7: busy lasts one cycle and the next beat is four bytes on
    a_r7_second_beat: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !req_ready) |=>
            (mem_valid && req_ready && mem_be == '1 && mem_addr == $past(mem_addr) + ADDR_W'(WORD_B)));

    // R9: a load result follows a read beat two cycles earlier
    a_r9_result_after_read: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> $past(mem_valid && !mem_write, 2));

endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (.*);

// File: tb/lsu_lane_align_test.sv
module lsu_lane_align_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_store = 1'b0;
    logic [1:0]  req_mode = '0;
    logic [1:0]  req_size = '0;
    logic        req_sext = 1'b0;
    logic        big_endian = 1'b0;
    logic [31:0] req_base = '0;
    logic [31:0] req_index = '0;
    logic [15:0] req_disp = '0;
    logic [63:0] req_wdata = '0;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        misalign, ld_valid;
    logic [63:0] ld_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_lane_align uut (.*);

    // memory model: 16 words, read data one cycle after the beat
    logic [31:0] mem [16];
    always @(posedge clk) begin
        if (rst) begin
            mem[0] <= 32'h8899AABB;
            mem[1] <= 32'h11223344;
        end else if (mem_valid) begin
            if (mem_write) begin
                for (int i = 0; i < 4; i++)
                    if (mem_be[i]) mem[mem_addr[5:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[5:2]];
            end
        end
    end

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic set_req(input logic st, input logic [1:0] md, input logic [1:0] sz,
                           input logic sx, input logic be, input logic [31:0] b,
                           input logic [31:0] ix, input logic [15:0] d, input logic [63:0] w);
        req_store = st; req_mode = md; req_size = sz; req_sext = sx; big_endian = be;
        req_base = b; req_index = ix; req_disp = d; req_wdata = w; req_valid = 1'b1;
    endtask

    typedef struct packed {
        logic        st;
        logic [1:0]  mode;
        logic [1:0]  size;
        logic        sx;
        logic        big;
        logic [31:0] base;
        logic [31:0] idx;
        logic [15:0] disp;
        logic [63:0] wdat;
        logic [31:0] e_addr;
        logic [3:0]  e_be;
        logic [31:0] e_wd;
        logic        e_mis;
        logic [63:0] e_ld;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        // R1 R5: displacement, LE signed byte at offset 1
        '{1'b0,2'd0,2'd0,1'b1,1'b0,32'hF0,32'h0,16'h11,64'h0,32'h101,4'b0010,32'h0,1'b0,64'hFFFFFFFF_FFFFFFAA,8'd1},
        // R2: register pair, BE unsigned byte at offset 1
        '{1'b0,2'd1,2'd0,1'b0,1'b1,32'h100,32'h1,16'h0,64'h0,32'h101,4'b0100,32'h0,1'b0,64'h99,8'd2},
        // R3: scaled half, LE signed
        '{1'b0,2'd2,2'd1,1'b1,1'b0,32'h100,32'h1,16'h0,64'h0,32'h102,4'b1100,32'h0,1'b0,64'hFFFFFFFF_FFFF8899,8'd3},
        // R5: BE unsigned half at offset 2
        '{1'b0,2'd0,2'd1,1'b0,1'b1,32'h100,32'h0,16'h2,64'h0,32'h102,4'b0011,32'h0,1'b0,64'hAABB,8'd5},
        // R5: signed word
        '{1'b0,2'd0,2'd2,1'b1,1'b0,32'h100,32'h0,16'h0,64'h0,32'h100,4'b1111,32'h0,1'b0,64'hFFFFFFFF_8899AABB,8'd5},
        // R3: scaled word, BE unsigned
        '{1'b0,2'd2,2'd2,1'b0,1'b1,32'hFC,32'h1,16'h0,64'h0,32'h100,4'b1111,32'h0,1'b0,64'h8899AABB,8'd3},
        // R3 R8: scaled double, LE
        '{1'b0,2'd2,2'd3,1'b0,1'b0,32'hF8,32'h1,16'h0,64'h0,32'h100,4'b1111,32'h0,1'b0,64'h11223344_8899AABB,8'd8},
        // R8: double, BE
        '{1'b0,2'd0,2'd3,1'b0,1'b1,32'h100,32'h0,16'h0,64'h0,32'h100,4'b1111,32'h0,1'b0,64'h8899AABB_11223344,8'd8},
        // R6: odd half
        '{1'b0,2'd0,2'd1,1'b0,1'b0,32'h100,32'h0,16'h1,64'h0,32'h0,4'b0,32'h0,1'b1,64'h0,8'd6},
        // R6: word at offset 2
        '{1'b0,2'd1,2'd2,1'b0,1'b0,32'h100,32'h2,16'h0,64'h0,32'h0,4'b0,32'h0,1'b1,64'h0,8'd6},
        // R2: mode 3 acts as pair, LE byte at offset 3
        '{1'b0,2'd3,2'd0,1'b0,1'b0,32'h100,32'h3,16'h0,64'h0,32'h103,4'b1000,32'h0,1'b0,64'h88,8'd2},
        // R6: double store not on an 8-byte boundary
        '{1'b1,2'd0,2'd3,1'b0,1'b0,32'h104,32'h0,16'h0,64'h1,32'h0,4'b0,32'h0,1'b1,64'h0,8'd6},
        // R1: displacement with bit 15 set adds upward
        '{1'b1,2'd0,2'd0,1'b0,1'b0,32'h10000,32'h0,16'h8000,64'h77,32'h18000,4'b0001,32'h77,1'b0,64'h0,8'd1},
        // R4: LE byte store at offset 3
        '{1'b1,2'd0,2'd0,1'b0,1'b0,32'h100,32'h0,16'h3,64'h5A,32'h103,4'b1000,32'h5A000000,1'b0,64'h0,8'd4},
        // R4: BE byte store at offset 3
        '{1'b1,2'd0,2'd0,1'b0,1'b1,32'h100,32'h0,16'h3,64'h5A,32'h103,4'b0001,32'h5A,1'b0,64'h0,8'd4},
        // R4: BE half store at offset 0
        '{1'b1,2'd1,2'd1,1'b0,1'b1,32'h100,32'h0,16'h0,64'h1234,32'h100,4'b1100,32'h12340000,1'b0,64'h0,8'd4},
        // R3 R4: scaled LE half store, upper operand bits dropped
        '{1'b1,2'd2,2'd1,1'b0,1'b0,32'h100,32'h1,16'h0,64'hFFFF1234,32'h102,4'b1100,32'h12340000,1'b0,64'h0,8'd4}
    };

    task automatic wait_result(input string rq, input logic [63:0] exp, input bit dbl);
        @(posedge clk); @(posedge clk);
        if (dbl) @(posedge clk);
        @(negedge clk);
        chk(rq, "ld_valid", ld_valid, 1);
        chk(rq, "ld_data", ld_data, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "mem_valid in reset", mem_valid, 0);
        chk("R10", "req_ready in reset", req_ready, 1);
        chk("R10", "ld_valid in reset", ld_valid, 0);
        chk("R10", "misalign in reset", misalign, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[v].rq);
            set_req(VEC[v].st, VEC[v].mode, VEC[v].size, VEC[v].sx, VEC[v].big,
                    VEC[v].base, VEC[v].idx, VEC[v].disp, VEC[v].wdat);
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            if (VEC[v].e_mis) begin
                chk(tag, "misalign", misalign, 1);
                chk(tag, "mem_valid on misalign", mem_valid, 0);
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    chk(tag, "no beat/result after misalign", {mem_valid, ld_valid}, 2'b00);
                end
            end else begin
                chk(tag, "mem_valid", mem_valid, 1);
                chk(tag, "mem_write", mem_write, VEC[v].st);
                chk(tag, "mem_addr", mem_addr, VEC[v].e_addr);
                chk(tag, "mem_be", mem_be, VEC[v].e_be);
                if (VEC[v].st) chk(tag, "mem_wdata", mem_wdata, VEC[v].e_wd);
                else wait_result(tag, VEC[v].e_ld, VEC[v].size == 2'd3);
            end
            repeat (2) @(negedge clk);
        end

        // R7 R8: BE double store, then a byte store held through the busy cycle
        set_req(1'b1, 2'd0, 2'd3, 1'b0, 1'b1, 32'h100, 32'h0, 16'h0, 64'hCAFEBABE_DEADBEEF);
        @(posedge clk); @(negedge clk);
        chk("R7", "req_ready during first beat", req_ready, 0);
        chk("R8", "first beat data", mem_wdata, 32'hCAFEBABE);
        chk("R7", "first beat addr", mem_addr, 32'h100);
        set_req(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 32'h108, 32'h0, 16'h0, 64'h33);
        @(posedge clk); @(negedge clk);
        chk("R7", "second beat addr", mem_addr, 32'h104);
        chk("R8", "second beat data", mem_wdata, 32'hDEADBEEF);
        chk("R7", "second beat enables", mem_be, 4'hF);
        chk("R7", "req_ready after second beat", req_ready, 1);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R7", "held request taken after busy", {mem_addr, mem_be, mem_wdata},
            {32'h108, 4'b0001, 32'h33});
        repeat (2) @(negedge clk);

        // R8: read the double back in both orders
        set_req(1'b0, 2'd0, 2'd3, 1'b0, 1'b1, 32'h100, 32'h0, 16'h0, 64'h0);
        @(posedge clk); @(negedge clk); req_valid = 1'b0;
        wait_result("R8", 64'hCAFEBABE_DEADBEEF, 1);
        repeat (2) @(negedge clk);
        set_req(1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 32'h100, 32'h0, 16'h0, 64'h0);
        @(posedge clk); @(negedge clk); req_valid = 1'b0;
        wait_result("R8", 64'hDEADBEEF_CAFEBABE, 1);
        repeat (2) @(negedge clk);

        // R9: back-to-back byte loads
        set_req(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 32'h100, 32'h0, 16'h0, 64'h0);
        @(posedge clk); @(negedge clk);
        chk("R9", "first load addr", mem_addr, 32'h100);
        chk("R9", "ready for next narrow", req_ready, 1);
        req_disp = 16'h1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R9", "second load addr next cycle", mem_addr, 32'h101);
        chk("R9", "no result yet", ld_valid, 0);
        @(posedge clk); @(negedge clk);
        chk("R9", "first result", {ld_valid, ld_data}, {1'b1, 64'hBE});
        @(posedge clk); @(negedge clk);
        chk("R9", "second result", {ld_valid, ld_data}, {1'b1, 64'hBA});
        @(posedge clk); @(negedge clk);
        chk("R9", "result pulse ends", ld_valid, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule